// File: doc/BRIEF.md
# Signature Store Frame Decoder

This block listens to the write side of a processor's data-memory port. It picks out full-word stores to one signature address, which software can change at any time. Test software sends small messages to the verification environment through that address. The block takes those stores apart and turns them into qualified output events.

Each message starts with a header word. Bits [7:0] of the header give the message kind, and bits [31:8] carry a 24-bit argument. The kind also decides how many follow-on data stores belong to the message:
- a status report or a pass/fail verdict takes no further words;
- a control-register report takes exactly one more word, the register value;
- a register dump takes one word for each general-purpose register, in ascending register order.

The decoder does not judge any of the values it reports. It only counts headers whose kind it does not recognise.

Top module: `sigwatch_decoder`

## Requirements
- R1: A store counts as signature traffic only in a cycle where bus_valid=1, bus_ready=1, bus_be=4'hF and bus_addr equals sig_addr. Any other store produces no output event and does not change the decoder state.
- R2: A header whose bits [7:0] equal 0 (status) produces status_valid high for exactly one cycle, in the cycle after the store. status_code then equals header bits [31:8].
- R3: A header whose bits [7:0] equal 1 (verdict) produces result_valid for one cycle, in the cycle after the store. result_pass is 1 when header bits [31:8] are zero and 0 for any other value.
- R4: A header whose bits [7:0] equal 2 (dump) has its bits [31:8] ignored. The next DUMP_REGS signature stores are emitted one by one on gpr_valid, with gpr_idx counting 0, 1, … up to DUMP_REGS-1 and gpr_data holding the stored word. Each event appears in the cycle after its store.
- R5: dump_done pulses together with the gpr_valid event whose index is DUMP_REGS-1. The signature store after that one is decoded as a header.
- R6: A header whose bits [7:0] equal 3 (control register) stores its bits [31:8] as the register address. The next signature store is the value. One cycle after the value store, csr_valid pulses with csr_addr and csr_data holding the pair.
- R7: While a dump or a control-register message is waiting for data, every signature store is taken as data, even when its low byte looks like a header kind. Idle cycles and non-signature stores do not break the message.
- R8: A header whose bits [7:0] hold a value from 4 to 255 raises no output event and increments err_count. err_count stops at its all-ones value. The next signature store is decoded as a header.
- R9: A synchronous active-high rst clears every valid output, err_count and any half-received message. The first signature store after reset is decoded as a header.
- R10: sig_addr is compared in the same cycle as the store. A new value takes effect for the very next store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_addr | input | ADDR_W | Signature address to match |
| bus_valid | input | 1 | Monitored store request valid |
| bus_ready | input | 1 | Monitored store request accepted |
| bus_addr | input | ADDR_W | Store address |
| bus_wdata | input | 32 | Store data |
| bus_be | input | 4 | Store byte enables |
| status_valid | output | 1 | Status report event |
| status_code | output | 24 | Reported status code |
| result_valid | output | 1 | Verdict event |
| result_pass | output | 1 | Verdict is pass |
| gpr_valid | output | 1 | Dump word event |
| gpr_idx | output | IDX_W | Register index of the dump word |
| gpr_data | output | 32 | Dump word value |
| dump_done | output | 1 | Last dump word emitted |
| csr_valid | output | 1 | Control-register pair event |
| csr_addr | output | 24 | Control-register address |
| csr_data | output | 32 | Control-register value |
| err_count | output | ERR_W | Saturating count of unknown headers |

## Verification
The bench builds the decoder with DUMP_REGS left at 32, so it drives the full register-dump sequence, including the final index and the header that follows it. It sets ERR_W to 3, so the error counter reaches its all-ones value of 7 after seven unknown headers. Further unknown headers then show that the counter stays saturated. ADDR_W stays at 32, so the suggested address 0x8FFFFFFC can be used before the bench moves sig_addr to a new value.

// File: rtl/sigwatch_pkg.sv
package sigwatch_pkg;
  localparam int WORD_W = 32;
  localparam int KIND_W = 8;
  localparam int ARG_W  = WORD_W - KIND_W;
  localparam int BE_W   = WORD_W / 8;

  localparam logic [KIND_W-1:0] K_STATUS = 8'd0;
  localparam logic [KIND_W-1:0] K_RESULT = 8'd1;
  localparam logic [KIND_W-1:0] K_DUMP   = 8'd2;
  localparam logic [KIND_W-1:0] K_CSR    = 8'd3;

  typedef enum logic [1:0] {ST_HDR, ST_DUMP, ST_CSRV} sw_state_e;

  function automatic logic [KIND_W-1:0] hdr_kind(input logic [WORD_W-1:0] w);
    return w[KIND_W-1:0];
  endfunction

  function automatic logic [ARG_W-1:0] hdr_arg(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:KIND_W];
  endfunction

  function automatic logic kind_known(input logic [KIND_W-1:0] k);
    return k <= K_CSR;
  endfunction
endpackage

// File: rtl/sigwatch_filter.sv
module sigwatch_filter
  import sigwatch_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              bus_valid,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BE_W-1:0]   bus_be,
  input  logic [ADDR_W-1:0] sig_addr,
  output logic              take
);
  logic handshake, full_word, addr_hit;
  assign handshake = bus_valid & bus_ready;
  assign full_word = &bus_be;
  assign addr_hit  = (bus_addr == sig_addr);
  assign take      = handshake & full_word & addr_hit;
endmodule

// File: rtl/sigwatch_errcnt.sv
module sigwatch_errcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bump,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;
  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)                 cnt <= '0;
    else if (bump && !at_top) cnt <= cnt + 1'b1;
  end

  p_sat_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt == TOP) |=> (cnt == TOP));
  p_step_r8: assert property (@(posedge clk) disable iff (rst)
    (bump && cnt != TOP) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sigwatch_fsm.sv
module sigwatch_fsm
  import sigwatch_pkg::*;
#(
  parameter int DUMP_REGS = 32,
  localparam int IDX_W = $clog2(DUMP_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [WORD_W-1:0] wdata,
  output logic              status_valid,
  output logic [ARG_W-1:0]  status_code,
  output logic              result_valid,
  output logic              result_pass,
  output logic              gpr_valid,
  output logic [IDX_W-1:0]  gpr_idx,
  output logic [WORD_W-1:0] gpr_data,
  output logic              dump_done,
  output logic              csr_valid,
  output logic [ARG_W-1:0]  csr_addr,
  output logic [WORD_W-1:0] csr_data,
  output logic              bad_hdr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DUMP_REGS - 1);

  sw_state_e        state;
  logic [IDX_W-1:0] idx;
  logic [ARG_W-1:0] csr_hold;

  logic hdr_take, dump_take, csrv_take;
  logic [KIND_W-1:0] kind;
  assign kind      = hdr_kind(wdata);
  assign hdr_take  = take && (state == ST_HDR);
  assign dump_take = take && (state == ST_DUMP);
  assign csrv_take = take && (state == ST_CSRV);
  assign bad_hdr   = hdr_take && !kind_known(kind);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_HDR;
      idx          <= '0;
      csr_hold     <= '0;
      status_valid <= 1'b0;
      status_code  <= '0;
      result_valid <= 1'b0;
      result_pass  <= 1'b0;
      gpr_valid    <= 1'b0;
      gpr_idx      <= '0;
      gpr_data     <= '0;
      dump_done    <= 1'b0;
      csr_valid    <= 1'b0;
      csr_addr     <= '0;
      csr_data     <= '0;
    end else begin
      status_valid <= 1'b0;
      result_valid <= 1'b0;
      gpr_valid    <= 1'b0;
      dump_done    <= 1'b0;
      csr_valid    <= 1'b0;
      if (hdr_take) begin
        case (kind)
          K_STATUS: begin
            status_valid <= 1'b1;
            status_code  <= hdr_arg(wdata);
          end
          K_RESULT: begin
            result_valid <= 1'b1;
            result_pass  <= (hdr_arg(wdata) == '0);
          end
          K_DUMP: begin
            state <= ST_DUMP;
            idx   <= '0;
          end
          K_CSR: begin
            state    <= ST_CSRV;
            csr_hold <= hdr_arg(wdata);
          end
          default: ;
        endcase
      end
      if (dump_take) begin
        gpr_valid <= 1'b1;
        gpr_idx   <= idx;
        gpr_data  <= wdata;
        if (idx == LAST) begin
          dump_done <= 1'b1;
          state     <= ST_HDR;
        end else begin
          idx <= idx + 1'b1;
        end
      end
      if (csrv_take) begin
        csr_valid <= 1'b1;
        csr_addr  <= csr_hold;
        csr_data  <= wdata;
        state     <= ST_HDR;
      end
    end
  end

  p_single_event_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({status_valid, result_valid, gpr_valid, csr_valid}));
  p_event_needs_take_r1: assert property (@(posedge clk) disable iff (rst)
    (status_valid || result_valid || gpr_valid || csr_valid) |-> $past(take));
  p_done_on_last_r5: assert property (@(posedge clk) disable iff (rst)
    dump_done |-> (gpr_valid && gpr_idx == LAST));
  p_header_after_done_r5: assert property (@(posedge clk) disable iff (rst)
    dump_done |=> !gpr_valid);
  p_csr_after_hdr_r6: assert property (@(posedge clk) disable iff (rst)
    csr_valid |-> !$past(hdr_take));
endmodule

// File: rtl/sigwatch_decoder.sv
module sigwatch_decoder
  import sigwatch_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DUMP_REGS = 32,
  parameter int ERR_W     = 8,
  localparam int IDX_W    = $clog2(DUMP_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] sig_addr,
  input  logic              bus_valid,
  input  logic              bus_ready,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic [BE_W-1:0]   bus_be,
  output logic              status_valid,
  output logic [ARG_W-1:0]  status_code,
  output logic              result_valid,
  output logic              result_pass,
  output logic              gpr_valid,
  output logic [IDX_W-1:0]  gpr_idx,
  output logic [WORD_W-1:0] gpr_data,
  output logic              dump_done,
  output logic              csr_valid,
  output logic [ARG_W-1:0]  csr_addr,
  output logic [WORD_W-1:0] csr_data,
  output logic [ERR_W-1:0]  err_count
);
  logic take_w, bad_hdr_w;

  sigwatch_filter #(.ADDR_W(ADDR_W)) u_filter (
    .bus_valid (bus_valid),
    .bus_ready (bus_ready),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .sig_addr  (sig_addr),
    .take      (take_w)
  );

  sigwatch_fsm #(.DUMP_REGS(DUMP_REGS)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .take         (take_w),
    .wdata        (bus_wdata),
    .status_valid (status_valid),
    .status_code  (status_code),
    .result_valid (result_valid),
    .result_pass  (result_pass),
    .gpr_valid    (gpr_valid),
    .gpr_idx      (gpr_idx),
    .gpr_data     (gpr_data),
    .dump_done    (dump_done),
    .csr_valid    (csr_valid),
    .csr_addr     (csr_addr),
    .csr_data     (csr_data),
    .bad_hdr      (bad_hdr_w)
  );

  sigwatch_errcnt #(.W(ERR_W)) u_err (
    .clk  (clk),
    .rst  (rst),
    .bump (bad_hdr_w),
    .cnt  (err_count)
  );

  p_take_qualified_r1: assert property (@(posedge clk) disable iff (rst)
    take_w |-> (bus_valid && bus_ready && bus_be == 4'hF));
endmodule

// File: tb/tb_sigwatch_decoder.sv
module tb_sigwatch_decoder;
  localparam int PERIOD = 10;
  localparam int NREG   = 32;
  localparam int EW     = 3;
  localparam logic [31:0] SIG0 = 32'h8FFF_FFFC;

  logic clk = 1'b0;
  logic rst;
  logic [31:0] sig_addr, bus_addr, bus_wdata;
  logic bus_valid, bus_ready;
  logic [3:0] bus_be;
  logic status_valid, result_valid, result_pass, gpr_valid, dump_done, csr_valid;
  logic [23:0] status_code, csr_addr;
  logic [4:0] gpr_idx;
  logic [31:0] gpr_data, csr_data;
  logic [EW-1:0] err_count;

  always #(PERIOD/2) clk = ~clk;

  sigwatch_decoder #(.ADDR_W(32), .DUMP_REGS(NREG), .ERR_W(EW)) dut (
    .clk(clk), .rst(rst), .sig_addr(sig_addr),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be),
    .status_valid(status_valid), .status_code(status_code),
    .result_valid(result_valid), .result_pass(result_pass),
    .gpr_valid(gpr_valid), .gpr_idx(gpr_idx), .gpr_data(gpr_data),
    .dump_done(dump_done), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_data(csr_data), .err_count(err_count)
  );

  int checks = 0;
  int fails  = 0;

  // reference model state: 0 header, 1 dump, 2 csr value
  int m_state = 0;
  int m_idx = 0;
  int m_err = 0;
  logic [23:0] m_csr = '0;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic v, input logic rd,
                      input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    logic acc;
    logic e_st, e_res, e_pass, e_gpr, e_done, e_csr;
    logic [23:0] e_code, e_caddr;
    logic [31:0] e_gdata, e_cdata;
    int e_idx;
    rst = r; bus_valid = v; bus_ready = rd; bus_addr = a; bus_wdata = d; bus_be = be;
    acc = !r && v && rd && (be == 4'hF) && (a == sig_addr);
    {e_st, e_res, e_pass, e_gpr, e_done, e_csr} = '0;
    e_code = '0; e_caddr = '0; e_gdata = '0; e_cdata = '0; e_idx = 0;
    if (r) begin
      m_state = 0; m_err = 0; m_idx = 0;
    end else if (acc) begin
      if (m_state == 1) begin
        e_gpr = 1; e_idx = m_idx; e_gdata = d;
        if (m_idx == NREG - 1) begin e_done = 1; m_state = 0; end
        else m_idx++;
      end else if (m_state == 2) begin
        e_csr = 1; e_caddr = m_csr; e_cdata = d; m_state = 0;
      end else begin
        case (d[7:0])
          8'd0: begin e_st = 1; e_code = d[31:8]; end
          8'd1: begin e_res = 1; e_pass = (d[31:8] == 0); end
          8'd2: begin m_state = 1; m_idx = 0; end
          8'd3: begin m_state = 2; m_csr = d[31:8]; end
          default: if (m_err < (1 << EW) - 1) m_err++;
        endcase
      end
    end
    @(negedge clk);
    chk({tag, "/R2"}, "status_valid", 32'(status_valid), 32'(e_st));
    if (e_st) chk({tag, "/R2"}, "status_code", 32'(status_code), 32'(e_code));
    chk({tag, "/R3"}, "result_valid", 32'(result_valid), 32'(e_res));
    if (e_res) chk({tag, "/R3"}, "result_pass", 32'(result_pass), 32'(e_pass));
    chk({tag, "/R4"}, "gpr_valid", 32'(gpr_valid), 32'(e_gpr));
    if (e_gpr) begin
      chk({tag, "/R4"}, "gpr_idx", 32'(gpr_idx), 32'(e_idx));
      chk({tag, "/R4"}, "gpr_data", gpr_data, e_gdata);
    end
    chk({tag, "/R5"}, "dump_done", 32'(dump_done), 32'(e_done));
    chk({tag, "/R6"}, "csr_valid", 32'(csr_valid), 32'(e_csr));
    if (e_csr) begin
      chk({tag, "/R6"}, "csr_addr", 32'(csr_addr), 32'(e_caddr));
      chk({tag, "/R6"}, "csr_data", csr_data, e_cdata);
    end
    chk({tag, "/R8"}, "err_count", 32'(err_count), 32'(m_err));
  endtask

  task automatic sw(input string tag, input logic [31:0] d);
    step(tag, 1'b0, 1'b1, 1'b1, sig_addr, d, 4'hF);
  endtask

  task automatic idle(input string tag);
    step(tag, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 4'h0);
  endtask

  initial begin
    sig_addr = SIG0;
    rst = 1'b1; bus_valid = 1'b0; bus_ready = 1'b0; bus_addr = '0; bus_wdata = '0; bus_be = '0;
    step("R9", 1'b1, 1'b0, 1'b0, 0, 0, 0);
    step("R9", 1'b1, 1'b1, 1'b1, SIG0, 32'h0000_0200, 4'hF);
    idle("R9");
    // status and verdict headers
    sw("R2", 32'h0000_0200);
    sw("R2", 32'hABCD_EF00);
    sw("R3", 32'h0000_0001);
    sw("R3", 32'h0000_0501);
    idle("R3");
    // store qualification
    step("R1", 1'b0, 1'b1, 1'b1, 32'h8FFF_FFF8, 32'h0000_0700, 4'hF);
    step("R1", 1'b0, 1'b1, 1'b0, SIG0, 32'h0000_0700, 4'hF);
    step("R1", 1'b0, 1'b0, 1'b1, SIG0, 32'h0000_0700, 4'hF);
    step("R1", 1'b0, 1'b1, 1'b1, SIG0, 32'h0000_0700, 4'h7);
    sw("R1", 32'h0000_0700);
    // control-register pair, broken by idle and foreign stores
    sw("R6", 32'h0003_0403);
    idle("R7");
    step("R7", 1'b0, 1'b1, 1'b1, 32'h0000_1000, 32'h0000_0000, 4'hF);
    sw("R6", 32'hDEAD_BEEF);
    sw("R6", 32'h0000_0003);
    sw("R7", 32'h0000_0001);
    // register dump with look-alike headers and interruptions
    sw("R4", 32'h1234_5602);
    for (int i = 0; i < NREG; i++) begin
      if (i == 4)       sw("R7", 32'h0000_0003);
      else if (i == 5)  sw("R7", 32'h0000_0102);
      else begin
        if (i == 10) begin
          idle("R7");
          step("R7", 1'b0, 1'b1, 1'b1, 32'h4, 32'h0000_0001, 4'hF);
        end
        sw("R4", 32'hA000_0000 + 32'(i * 3));
      end
    end
    sw("R5", 32'h0000_0900);
    sw("R5", 32'h0000_0002);
    for (int i = 0; i < NREG; i++) sw("R5", 32'(i));
    idle("R5");
    // unknown kinds saturate the counter
    for (int i = 0; i < 9; i++) sw("R8", 32'h0000_0004 + 32'(i * 29));
    sw("R8", 32'h0000_00FF);
    sw("R8", 32'h0000_0300);
    // signature address change
    sig_addr = 32'h0000_2000;
    step("R10", 1'b0, 1'b1, 1'b1, SIG0, 32'h0000_0400, 4'hF);
    sw("R10", 32'h0000_0500);
    sig_addr = SIG0;
    sw("R10", 32'h0000_0600);
    // reset in the middle of a dump
    sw("R9", 32'h0000_0002);
    sw("R9", 32'h1111_1111);
    sw("R9", 32'h2222_2222);
    step("R9", 1'b1, 1'b0, 1'b0, 0, 0, 0);
    sw("R9", 32'h0000_0800);
    sw("R9", 32'h0000_0003);
    sw("R9", 32'h5555_0000);
    idle("R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule